// File: doc/BRIEF.md
# Page Access Permission Checker and Fault Recorder

This block sits after the table walker of a 32-bit paged memory management unit. For each translated access it takes the kind of access (load, store or instruction fetch), the privilege level of the requester and the leaf page entry's 3-bit access-control code and modified flag. It decides whether the access is legal and which read/write/execute rights can be cached for the page. When the walker itself has already failed, its encoded error is passed through instead. No table walking or translation caching happens here.

Faults are written into a fault status register and a fault address register that software reads. A read pulse clears the status register. A fault that comes before software has read the previous one marks the overflow bit. The block can run in a no-fault mode, and it can also see that traps are disabled. In both cases a fault is recorded but no trap is raised, and full rights are granted so the requester can go on.

The decision outputs are combinational in the request cycle. The two registers update on the clock edge that ends the request cycle.

Top module: `mmu_prot_unit`

## Requirements
- R1: The access index is 3 bits: bit 2 = store, bit 1 = instruction fetch, bit 0 = supervisor. Access kind encoding on `req_kind`: 0 load, 1 store, 2 fetch, 3 treated as load.
- R2: A user access to a page with access code 6 or 7 gives a privilege error, code 12 (status bits 4:2 = 3).
- R3: In every other case, an access whose needed right is missing from its mode's rights gives a protection error, code 8 (status bits 4:2 = 2). A load needs R, a store needs W and a fetch needs X.
- R4: Granted rights on `perm_rwx` (bit 2 R, bit 1 W, bit 0 X) for access codes 0 to 7:
  - Supervisor: R, RW, RX, RWX, X, RW, RX, RWX.
  - User: R, RW, RX, RWX, X, R, none, none.
- R5: When the page entry's modified flag is clear and there is no fault, W is removed from the granted rights.
- R6: When no-fault mode is on, an access error of a user request is ignored, and normal rights are granted without a fault. Supervisor access errors are not ignored.
- R7: When a fault is recorded, the new status value is built as follows:
  - Start with 1 if the status register was nonzero (overflow), otherwise 0.
  - OR in the access index shifted left by 5.
  - OR in the error code.
  - OR in 2 (address valid).
- R8: Every fault loads the fault address register with the request address with its low page-offset bits cleared (4 KiB pages by default).
- R9: A fault while no-fault mode is on, or while traps are disabled, grants RWX and raises no trap. A fault with no-fault mode off and traps enabled raises `trap_req` with rights 000.
- R10: On a trap, `trap_fetch` is 1 for an instruction fetch (instruction fault) and 0 for any other kind of access (data fault).
- R11: A walk error always faults and skips the access check. Its code is level in bits 9:8 and type in bits 4:2 (1 = invalid entry, 4 = translation error).
- R12: A status read pulse clears the status register on the next edge. A fault in the same cycle takes priority, as if no read had occurred.
- R13: After reset both registers are zero. With no request, `trap_req` is 0 and `perm_rwx` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A translated access is presented this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_super | input | 1 | Request comes from supervisor mode |
| pte_acc | input | 3 | Access-control code of the leaf entry |
| pte_mod | input | 1 | Modified flag of the leaf entry |
| nofault_en | input | 1 | No-fault mode |
| trap_en | input | 1 | Traps enabled |
| walk_err | input | 1 | Table walk failed |
| walk_lvl | input | 2 | Level at which the walk failed |
| walk_type | input | 3 | Walk fault type |
| req_vaddr | input | VA_W | Virtual address of the access |
| fsr_rd | input | 1 | Software read pulse for the status register |
| trap_req | output | 1 | Raise a fault trap |
| trap_fetch | output | 1 | Trap is an instruction fault |
| perm_rwx | output | 3 | Granted rights R, W, X |
| fsr_q | output | 10 | Fault status register |
| far_q | output | VA_W | Fault address register |

## Verification
The bench sweeps every access code for every reachable access index against its own error table and rights table. A wrong threshold for privilege errors, or a rights entry from the wrong mode, shows up as a trap or rights mismatch. Directed vectors target the cases that are easy to get wrong:
- No-fault suppression must apply to user requests only. A design that suppresses supervisor errors would skip the status update.
- A store to an unmodified page must lose W.
- A walk error must ignore the access code.

The status sequence checks the exact value with and without overflow, and checks a read that coincides with a fault. A design that lets the read win would show zero where the new fault value is expected.

// File: rtl/mmu_prot_pkg.sv
package mmu_prot_pkg;

  localparam int FSR_W    = 10;
  localparam int IDX_SHIFT = 5;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [2:0] PERM_R = 3'b100;
  localparam logic [2:0] PERM_W = 3'b010;
  localparam logic [2:0] PERM_X = 3'b001;

  localparam logic [FSR_W-1:0] CODE_NONE = FSR_W'(0);
  localparam logic [FSR_W-1:0] CODE_PROT = FSR_W'(8);
  localparam logic [FSR_W-1:0] CODE_PRIV = FSR_W'(12);
  localparam logic [FSR_W-1:0] FSR_AV    = FSR_W'(2);

  // index bits: [2] store, [1] fetch, [0] supervisor
  function automatic logic [2:0] access_index(acc_kind_e k, logic sup);
    return {k == KIND_STORE, k == KIND_FETCH, sup};
  endfunction

  // rights a mode may hold for a given access code
  function automatic logic [2:0] mode_perm(logic user, logic [2:0] acc);
    logic [2:0] p;
    if (acc == 3'd4)            p = PERM_X;
    else if (!user || !acc[2])  p = PERM_R | (acc[0] ? PERM_W : 3'b000)
                                           | (acc[1] ? PERM_X : 3'b000);
    else if (acc == 3'd5)       p = PERM_R;
    else                        p = 3'b000;
    return p;
  endfunction

  function automatic logic [2:0] needed_perm(logic [2:0] idx);
    logic [2:0] n;
    n = (idx[2] ? PERM_W : 3'b000) | (idx[1] ? PERM_X : 3'b000);
    if (n == 3'b000) n = PERM_R;
    return n;
  endfunction

  function automatic logic [FSR_W-1:0] access_error(logic [2:0] idx, logic [2:0] acc);
    logic user;
    user = !idx[0];
    if (user && acc[2:1] == 2'b11)
      return CODE_PRIV;
    else if ((needed_perm(idx) & ~mode_perm(user, acc)) != 3'b000)
      return CODE_PROT;
    else
      return CODE_NONE;
  endfunction

  function automatic logic [FSR_W-1:0] walk_code(logic [1:0] lvl, logic [2:0] typ);
    return {lvl, 3'b000, typ, 2'b00};
  endfunction

  function automatic logic [FSR_W-1:0] fsr_merge(logic [FSR_W-1:0] old,
                                                 logic [2:0] idx,
                                                 logic [FSR_W-1:0] code);
    logic [FSR_W-1:0] v;
    v = {{(FSR_W-1){1'b0}}, old != '0};
    v = v | (FSR_W'(idx) << IDX_SHIFT) | code | FSR_AV;
    return v;
  endfunction

endpackage

// File: rtl/mmu_acc_check.sv
module mmu_acc_check
  import mmu_prot_pkg::*;
(
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_super,
  input  logic [2:0]       pte_acc,
  input  logic             nofault_en,
  input  logic             walk_err,
  input  logic [1:0]       walk_lvl,
  input  logic [2:0]       walk_type,
  output logic [2:0]       acc_idx,
  output logic             acc_err_raw,
  output logic             fault_evt,
  output logic [FSR_W-1:0] fault_code
);
  acc_kind_e        kind;
  logic [FSR_W-1:0] err_code;
  logic             err_kept;

  always_comb begin
    kind        = acc_kind_e'(req_kind);
    if (kind == KIND_RSVD) kind = KIND_LOAD;
    acc_idx     = access_index(kind, req_super);
    err_code    = access_error(acc_idx, pte_acc);
    acc_err_raw = (err_code != CODE_NONE);
    // user errors vanish in no-fault mode
    err_kept    = acc_err_raw && !(nofault_en && !req_super);
    fault_evt   = req_valid && (walk_err || err_kept);
    fault_code  = walk_err ? walk_code(walk_lvl, walk_type) : err_code;
  end
endmodule

// File: rtl/mmu_perm_grant.sv
module mmu_perm_grant
  import mmu_prot_pkg::*;
(
  input  logic       req_valid,
  input  logic [2:0] acc_idx,
  input  logic [2:0] pte_acc,
  input  logic       pte_mod,
  input  logic       fault_evt,
  input  logic       quiet_fault,
  output logic [2:0] perm_rwx,
  output logic       trap_req,
  output logic       trap_fetch
);
  logic [2:0] base_perm;

  always_comb begin
    base_perm = mode_perm(!acc_idx[0], pte_acc);
    if (!pte_mod) base_perm = base_perm & ~PERM_W;
    perm_rwx   = 3'b000;
    trap_req   = 1'b0;
    if (req_valid) begin
      if (!fault_evt)       perm_rwx = base_perm;
      else if (quiet_fault) perm_rwx = PERM_R | PERM_W | PERM_X;
      else                  trap_req = 1'b1;
    end
    trap_fetch = trap_req && acc_idx[1];
  end
endmodule

// File: rtl/mmu_fault_rec.sv
module mmu_fault_rec
  import mmu_prot_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_evt,
  input  logic [2:0]       acc_idx,
  input  logic [FSR_W-1:0] fault_code,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             fsr_rd,
  output logic             ovf_evt,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q
);
  localparam logic [VA_W-1:0] OFS_MASK = VA_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic [FSR_W-1:0] fsr_d;
  logic [VA_W-1:0]  far_d;

  assign ovf_evt = fault_evt && (fsr_q != '0);

  always_comb begin
    fsr_d = fsr_q;
    if (fault_evt)   fsr_d = fsr_merge(fsr_q, acc_idx, fault_code);
    else if (fsr_rd) fsr_d = '0;
    far_d = fault_evt ? (req_vaddr & ~OFS_MASK) : far_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      fsr_q <= fsr_d;
      far_q <= far_d;
    end
  end
endmodule

// File: rtl/mmu_prot_unit.sv
module mmu_prot_unit
  import mmu_prot_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_super,
  input  logic [2:0]       pte_acc,
  input  logic             pte_mod,
  input  logic             nofault_en,
  input  logic             trap_en,
  input  logic             walk_err,
  input  logic [1:0]       walk_lvl,
  input  logic [2:0]       walk_type,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             fsr_rd,
  output logic             trap_req,
  output logic             trap_fetch,
  output logic [2:0]       perm_rwx,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q
);
  logic [2:0]       acc_idx;
  logic             acc_err_raw;
  logic             fault_evt;
  logic [FSR_W-1:0] fault_code;
  logic             quiet_fault;
  logic             ovf_evt;

  assign quiet_fault = nofault_en || !trap_en;

  mmu_acc_check chk_u (
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_super  (req_super),
    .pte_acc    (pte_acc),
    .nofault_en (nofault_en),
    .walk_err   (walk_err),
    .walk_lvl   (walk_lvl),
    .walk_type  (walk_type),
    .acc_idx    (acc_idx),
    .acc_err_raw(acc_err_raw),
    .fault_evt  (fault_evt),
    .fault_code (fault_code)
  );

  mmu_perm_grant perm_u (
    .req_valid  (req_valid),
    .acc_idx    (acc_idx),
    .pte_acc    (pte_acc),
    .pte_mod    (pte_mod),
    .fault_evt  (fault_evt),
    .quiet_fault(quiet_fault),
    .perm_rwx   (perm_rwx),
    .trap_req   (trap_req),
    .trap_fetch (trap_fetch)
  );

  mmu_fault_rec #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) rec_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_evt (fault_evt),
    .acc_idx   (acc_idx),
    .fault_code(fault_code),
    .req_vaddr (req_vaddr),
    .fsr_rd    (fsr_rd),
    .ovf_evt   (ovf_evt),
    .fsr_q     (fsr_q),
    .far_q     (far_q)
  );
endmodule

// File: rtl/mmu_prot_unit_chk.sv
module mmu_prot_unit_chk
  import mmu_prot_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             req_super,
  input logic [2:0]       pte_acc,
  input logic             pte_mod,
  input logic             nofault_en,
  input logic             trap_en,
  input logic             walk_err,
  input logic             fsr_rd,
  input logic             fault_evt,
  input logic             ovf_evt,
  input logic             trap_req,
  input logic             trap_fetch,
  input logic [2:0]       perm_rwx,
  input logic [FSR_W-1:0] fsr_q,
  input logic [VA_W-1:0]  far_q
);
  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_super && pte_acc[2:1] == 2'b11 && !walk_err && !nofault_en
      |-> fault_evt); // R2
  AST_NO_DIRTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !pte_mod && !fault_evt |-> !perm_rwx[1]); // R5
  AST_FSR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> fsr_q[1]); // R7
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> fsr_q[0]); // R7
  AST_FAR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> far_q[PAGE_BITS-1:0] == '0); // R8
  AST_QUIET_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt && (nofault_en || !trap_en) |-> !trap_req && perm_rwx == 3'b111); // R9
  AST_TRAP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> fault_evt && trap_fetch == (req_kind == 2'd2)); // R10
  AST_WALK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && walk_err |-> fault_evt); // R11
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_rd && !fault_evt |=> fsr_q == '0); // R12
  AST_FSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fsr_rd && !fault_evt |=> $stable(fsr_q)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !trap_req && perm_rwx == 3'b000); // R13
endmodule

bind mmu_prot_unit mmu_prot_unit_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_super (req_super),
  .pte_acc   (pte_acc),
  .pte_mod   (pte_mod),
  .nofault_en(nofault_en),
  .trap_en   (trap_en),
  .walk_err  (walk_err),
  .fsr_rd    (fsr_rd),
  .fault_evt (fault_evt),
  .ovf_evt   (ovf_evt),
  .trap_req  (trap_req),
  .trap_fetch(trap_fetch),
  .perm_rwx  (perm_rwx),
  .fsr_q     (fsr_q),
  .far_q     (far_q)
);

// File: tb/mmu_prot_unit_tb.sv
module mmu_prot_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_super = 0, pte_mod = 0, nofault_en = 0, trap_en = 0;
  logic walk_err = 0, fsr_rd = 0;
  logic [1:0] req_kind = 0, walk_lvl = 0;
  logic [2:0] pte_acc = 0, walk_type = 0;
  logic [VA_W-1:0] req_vaddr = 0;
  logic trap_req, trap_fetch;
  logic [2:0] perm_rwx;
  logic [9:0] fsr_q;
  logic [VA_W-1:0] far_q;

  int n_checks = 0;
  int n_errors = 0;
  logic [9:0] m_fsr = 0;
  logic [VA_W-1:0] m_far = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_prot_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_super(req_super), .pte_acc(pte_acc), .pte_mod(pte_mod),
    .nofault_en(nofault_en), .trap_en(trap_en), .walk_err(walk_err),
    .walk_lvl(walk_lvl), .walk_type(walk_type), .req_vaddr(req_vaddr),
    .fsr_rd(fsr_rd), .trap_req(trap_req), .trap_fetch(trap_fetch),
    .perm_rwx(perm_rwx), .fsr_q(fsr_q), .far_q(far_q)
  );

  // error rows per access index, 2 bits per code: 0 ok, 2 protection, 3 privilege
  localparam logic [15:0] ERR_ROW [6] = '{16'hF200, 16'h0200, 16'hF80A,
                                          16'h080A, 16'hFA22, 16'h2222};

  function automatic logic [9:0] b_err(logic [2:0] idx, logic [2:0] acc);
    logic [1:0] e;
    e = ERR_ROW[idx][2*acc +: 2];
    return (e == 2'd3) ? 10'd12 : (e == 2'd2) ? 10'd8 : 10'd0;
  endfunction

  function automatic logic [2:0] b_perm(logic sup, logic [2:0] acc);
    case ({sup, acc})
      4'h0, 4'h8: return 3'b100;
      4'h1, 4'h9: return 3'b110;
      4'h2, 4'hA: return 3'b101;
      4'h3, 4'hB: return 3'b111;
      4'h4, 4'hC: return 3'b001;
      4'h5:       return 3'b100;
      4'hD:       return 3'b110;
      4'hE:       return 3'b101;
      4'hF:       return 3'b111;
      default:    return 3'b000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] kind, input logic sup, input logic [2:0] acc,
                       input logic mod, input logic nf, input logic te,
                       input logic werr, input logic [1:0] wl, input logic [2:0] wt,
                       input logic rd, input logic [VA_W-1:0] va,
                       input logic xtrap, input logic [2:0] xperm, input string tag);
    logic [2:0] idx;
    logic [9:0] code;
    logic flt;
    idx  = {kind == 2'd1, kind == 2'd2, sup};
    code = werr ? {wl, 3'b000, wt, 2'b00} : b_err(idx, acc);
    flt  = werr || (code != 0 && !(nf && !sup));
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_super = sup; pte_acc = acc; pte_mod = mod;
    nofault_en = nf; trap_en = te; walk_err = werr; walk_lvl = wl; walk_type = wt;
    fsr_rd = rd; req_vaddr = va;
    #1;
    check(trap_req === xtrap, {tag, " trap"}, trap_req, xtrap);
    check(perm_rwx === xperm, {tag, " perm"}, perm_rwx, xperm);
    check(trap_fetch === (xtrap && kind == 2'd2), {tag, " R10 trap kind"},
          trap_fetch, xtrap && kind == 2'd2);
    if (flt) begin
      m_fsr = ((m_fsr != 0) ? 10'd1 : 10'd0) | (10'(idx) << 5) | code | 10'd2;
      m_far = {va[VA_W-1:12], 12'h000};
    end else if (rd) m_fsr = 0;
    @(negedge clk);
    req_valid = 0; fsr_rd = 0;
    #1;
    check(fsr_q === m_fsr, {tag, " R7 status"}, fsr_q, m_fsr);
    check(far_q === m_far, {tag, " R8 address"}, far_q, m_far);
  endtask

  task automatic read_clear();
    @(negedge clk); fsr_rd = 1;
    @(negedge clk); fsr_rd = 0; m_fsr = 0;
    #1 check(fsr_q === 10'd0, "R12 read clear", fsr_q, 0);
  endtask

  typedef struct packed {
    logic [1:0] kind; logic sup; logic [2:0] acc; logic mod; logic nf; logic te;
    logic werr; logic [1:0] wl; logic [2:0] wt; logic xtrap; logic [2:0] xperm;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 3'b000}, // R6 user suppressed
    '{2'd0, 1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 3'b111}, // R6 R9 sup not suppressed
    '{2'd1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 3'b100}, // R5
    '{2'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 3'b111}, // R9 traps off
    '{2'd2, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b1, 3'b000}, // R10 fetch trap
    '{2'd0, 1'b1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 3'd1, 1'b1, 3'b000}, // R11 walk invalid
    '{2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 3'd4, 1'b0, 3'b111}, // R11 walk xlate
    '{2'd1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 3'b110}  // R4
  };

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(fsr_q === 0, "R13 reset status", fsr_q, 0);
    check(far_q === 0, "R13 reset address", far_q, 0);
    check(trap_req === 0 && perm_rwx === 0, "R13 idle outputs", {trap_req, perm_rwx}, 0);
    rst_n = 1;

    for (int i = 0; i < 8; i++)
      apply(VECS[i].kind, VECS[i].sup, VECS[i].acc, VECS[i].mod, VECS[i].nf, VECS[i].te,
            VECS[i].werr, VECS[i].wl, VECS[i].wt, 1'b0, 32'h00A0_0000 + 32'(i) * 32'h1357,
            VECS[i].xtrap, VECS[i].xperm, $sformatf("vec%0d R4 R5 R6 R9 R11", i));

    read_clear();
    apply(2'd2, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 32'hDEAD_BEEF,
          1'b1, 3'b000, "R7 first fault");
    check(fsr_q === 10'h06A, "R7 exact no overflow", fsr_q, 10'h06A);
    apply(2'd1, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b1, 32'h1234_5FFF,
          1'b1, 3'b000, "R12 fault wins over read");
    check(fsr_q === 10'h08B, "R7 exact with overflow", fsr_q, 10'h08B);
    check(far_q === 32'h1234_5000, "R8 page aligned", far_q, 32'h1234_5000);
    read_clear();

    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 8; a++) begin
          logic [2:0] ix, p;
          logic [9:0] e;
          logic md;
          ix = {k == 1, k == 2, s[0]};
          md = a[0] ^ s[0];
          e  = b_err(ix, 3'(a));
          p  = b_perm(s[0], 3'(a)) & (md ? 3'b111 : 3'b101);
          apply(2'(k), s[0], 3'(a), md, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0,
                32'h4000_0000 + 32'(k * 16 + s * 8 + a) * 32'h1ABC,
                e != 0, (e != 0) ? 3'b000 : p,
                $sformatf("sweep k%0d s%0d a%0d R1 R2 R3 R4 R5", k, s, a));
        end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule